// File: doc/BRIEF.md
# PLL Fast-Lock Sequencer

This block shortens PLL settling after a new frequency is programmed. For a set number of comparison-clock cycles it widens the loop bandwidth. While that interval runs, the block drives the charge-pump current code to its maximum. It also closes a switch that grounds part of the loop-filter shunt resistance, which leaves one quarter of that resistance in the loop. When the count expires, the block gives back the programmed charge-pump code and opens the switch.

The sequencer runs only when three configuration fields hold one particular combination. That condition is called "armed". While the block is armed, a strobe that marks a write to the frequency register starts an interval. Register decoding, the analog switch and the loop filter are outside this block. It takes the already-decoded fields and the strobe as plain inputs, and it runs on the comparison clock.

Top module: `pll_boost_seq`

## Requirements
- R1: The block is armed only when `mode_cfg` is 2'b01, `cp_cfg` is 4'b0000 and `sel_cfg` is 4'b1100 at the same time. Any other combination leaves it disarmed.
- R2: If `freq_wr` is high at a rising clock edge while the block is armed and `dur_cfg` is nonzero, an interval starts in the cycle after that edge.
- R3: For every cycle of an interval, `cp_eff` is 4'b1111.
- R4: For every cycle of an interval, `shunt_sw` is 1. Outside an interval it is 0.
- R5: If the block stays armed and sees no further strobe, an interval lasts exactly `dur_cfg` cycles. `dur_cfg` is a 12-bit count from 1 to 4095.
- R6: In the cycle after an interval ends, `cp_eff` equals `cp_cfg` again and `shunt_sw` is 0.
- R7: A strobe that arrives during an interval restarts the interval. The interval then runs a full `dur_cfg` cycles counted from that strobe.
- R8: A strobe with `dur_cfg` equal to 0 starts no interval.
- R9: While the block is disarmed, `cp_eff` equals `cp_cfg`, `shunt_sw` is 0 and strobes are ignored. If the block becomes disarmed during an interval, the interval stops in that same cycle.
- R10: `seq_busy` is high exactly in the cycles where the forced settings apply. After reset, `seq_busy` and `shunt_sw` are 0 and `cp_eff` equals `cp_cfg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Comparison clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_cfg | input | 2 | Programmed lock-mode field |
| cp_cfg | input | 4 | Programmed charge-pump current code |
| sel_cfg | input | 4 | Programmed test-pin select field |
| dur_cfg | input | 12 | Interval length in comparison-clock cycles |
| freq_wr | input | 1 | One-cycle strobe for a frequency-register write |
| cp_eff | output | 4 | Charge-pump code sent to the pump |
| shunt_sw | output | 1 | Closes the filter-resistor shorting switch |
| seq_busy | output | 1 | High while the forced settings apply |

## Verification
The bench builds the block with its default parameters: a 2-bit mode field, 4-bit code and select fields, and a 12-bit duration. With these values the longest count, 4095, fits in a short run, so the bench checks that full-length interval cycle by cycle next to a one-cycle interval and a zero count. Because the code and select fields are only four bits wide, random stimulus lands on near-miss arming combinations often. It also lands on strobes that arrive during a running interval, which exercises the restart path.

// File: rtl/boost_pkg.sv
package boost_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_CLEAR = 2'd3
  } timer_act_t;

  function automatic timer_act_t pick_action(input logic armed, input logic trig,
                                             input logic dur_zero, input logic rem_zero);
    if (!armed)                 return ACT_CLEAR;
    else if (trig && !dur_zero) return ACT_LOAD;
    else if (!rem_zero)         return ACT_STEP;
    else                        return ACT_HOLD;
  endfunction
endpackage

// File: rtl/boost_arm_detect.sv
module boost_arm_detect #(
  parameter int MODE_W = 2,
  parameter int CP_W   = 4,
  parameter int SEL_W  = 4,
  parameter logic [MODE_W-1:0] ARM_MODE = 2'b01,
  parameter logic [SEL_W-1:0]  ARM_SEL  = 4'b1100
) (
  input  logic [MODE_W-1:0] mode_cfg,
  input  logic [CP_W-1:0]   cp_cfg,
  input  logic [SEL_W-1:0]  sel_cfg,
  output logic              armed
);
  logic mode_ok, cp_ok, sel_ok;
  assign mode_ok = (mode_cfg == ARM_MODE);
  assign cp_ok   = (cp_cfg == '0);
  assign sel_ok  = (sel_cfg == ARM_SEL);
  assign armed   = mode_ok && cp_ok && sel_ok;
endmodule

// File: rtl/boost_timer.sv
module boost_timer
  import boost_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             trig,
  input  logic [CNT_W-1:0] dur,
  output logic             running,
  output logic [CNT_W-1:0] remain
);
  timer_act_t act;
  logic dur_zero, rem_zero;

  assign dur_zero = (dur == '0);
  assign rem_zero = (remain == '0);
  assign act      = pick_action(armed, trig, dur_zero, rem_zero);
  assign running  = !rem_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= '0;
    else begin
      case (act)
        ACT_LOAD:  remain <= dur;
        ACT_STEP:  remain <= remain - 1'b1;
        ACT_CLEAR: remain <= '0;
        default:   remain <= remain;
      endcase
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trig && dur != '0) |=> (remain == $past(dur)));
  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !trig && remain != '0) |=> (remain == $past(remain) - 1'b1));
  // R9
  disarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed) |=> (remain == '0));
endmodule

// File: rtl/boost_out_mux.sv
module boost_out_mux #(
  parameter int CP_W = 4
) (
  input  logic            forced,
  input  logic [CP_W-1:0] cp_cfg,
  output logic [CP_W-1:0] cp_eff,
  output logic            shunt_sw
);
  assign cp_eff   = forced ? {CP_W{1'b1}} : cp_cfg;
  assign shunt_sw = forced;
endmodule

// File: rtl/pll_boost_seq.sv
module pll_boost_seq #(
  parameter int MODE_W = 2,
  parameter int CP_W   = 4,
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 12,
  parameter logic [MODE_W-1:0] ARM_MODE = 2'b01,
  parameter logic [SEL_W-1:0]  ARM_SEL  = 4'b1100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_cfg,
  input  logic [CP_W-1:0]   cp_cfg,
  input  logic [SEL_W-1:0]  sel_cfg,
  input  logic [CNT_W-1:0]  dur_cfg,
  input  logic              freq_wr,
  output logic [CP_W-1:0]   cp_eff,
  output logic              shunt_sw,
  output logic              seq_busy
);
  localparam logic [CP_W-1:0] CP_MAX = {CP_W{1'b1}};

  logic             armed;
  logic             running;
  logic             forced;
  logic [CNT_W-1:0] remain;

  boost_arm_detect #(
    .MODE_W(MODE_W), .CP_W(CP_W), .SEL_W(SEL_W),
    .ARM_MODE(ARM_MODE), .ARM_SEL(ARM_SEL)
  ) u_arm (
    .mode_cfg(mode_cfg), .cp_cfg(cp_cfg), .sel_cfg(sel_cfg), .armed(armed)
  );

  boost_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .armed(armed), .trig(freq_wr),
    .dur(dur_cfg), .running(running), .remain(remain)
  );

  assign forced   = armed && running;
  assign seq_busy = forced;

  boost_out_mux #(.CP_W(CP_W)) u_mux (
    .forced(forced), .cp_cfg(cp_cfg), .cp_eff(cp_eff), .shunt_sw(shunt_sw)
  );

  // R3
  cp_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> (cp_eff == CP_MAX));
  // R4
  switch_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shunt_sw == seq_busy));
  // R9
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed) |-> (!shunt_sw && cp_eff == cp_cfg));
  // R8
  zero_dur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_wr && dur_cfg == '0 && remain == '0) |=> !seq_busy);
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (remain == 1 && !freq_wr) |=> (!shunt_sw && cp_eff == cp_cfg));
endmodule

// File: tb/pll_boost_seq_bench.sv
module pll_boost_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_cfg = 2'b00;
  logic [3:0]  cp_cfg = 4'h5;
  logic [3:0]  sel_cfg = 4'h0;
  logic [11:0] dur_cfg = 12'd0;
  logic        freq_wr = 1'b0;
  logic [3:0]  cp_eff;
  logic        shunt_sw, seq_busy;

  int checks = 0;
  int fails = 0;
  int exp_rem = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pll_boost_seq u_pll_boost_seq (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .cp_cfg(cp_cfg),
    .sel_cfg(sel_cfg), .dur_cfg(dur_cfg), .freq_wr(freq_wr),
    .cp_eff(cp_eff), .shunt_sw(shunt_sw), .seq_busy(seq_busy)
  );

  function automatic bit is_armed(input logic [1:0] m, input logic [3:0] c, input logic [3:0] s);
    return (m == 2'b01) && (c == 4'h0) && (s == 4'hC);
  endfunction

  function automatic int next_rem(input int rem, input bit arm, input bit wr, input int dur);
    if (!arm) return 0;
    if (wr && dur != 0) return dur;
    return (rem > 0) ? rem - 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) exp_rem <= 0;
    else exp_rem <= next_rem(exp_rem, is_armed(mode_cfg, cp_cfg, sel_cfg), freq_wr, int'(dur_cfg));

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare all outputs at the negedge against the model
  task automatic tick;
    bit arm, busy;
    @(negedge clk);
    arm  = is_armed(mode_cfg, cp_cfg, sel_cfg);
    busy = arm && exp_rem != 0;
    if (busy) begin
      check_eq("R3 cp_eff forced", int'(cp_eff), 15);
      check_eq("R4 switch closed", int'(shunt_sw), 1);
    end else if (!arm) begin
      check_eq("R9 cp_eff passthrough", int'(cp_eff), int'(cp_cfg));
      check_eq("R9 switch open", int'(shunt_sw), 0);
    end else begin
      check_eq("R6 cp_eff restored", int'(cp_eff), int'(cp_cfg));
      check_eq("R6 switch open", int'(shunt_sw), 0);
    end
    check_eq("R10 busy flag", int'(seq_busy), int'(busy));
  endtask

  task automatic arm_up(input logic [11:0] d);
    mode_cfg = 2'b01; cp_cfg = 4'h0; sel_cfg = 4'hC; dur_cfg = d;
  endtask

  task automatic strobe;
    freq_wr = 1'b1; tick(); freq_wr = 1'b0;
  endtask

  task automatic measure(input string tag, input int exp_len);
    int len = 0;
    strobe();
    while (seq_busy === 1'b1 && len < 5000) begin len++; tick(); end
    check_eq(tag, len, exp_len);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check_eq("R10 reset busy", int'(seq_busy), 0);
    check_eq("R10 reset cp_eff", int'(cp_eff), 5);
    rst_n = 1'b1;
    tick();

    // R1 near misses: strobe must not start anything
    mode_cfg = 2'b10; cp_cfg = 4'h0; sel_cfg = 4'hC; dur_cfg = 12'd6;
    strobe(); check_eq("R1 wrong mode", int'(seq_busy), 0);
    mode_cfg = 2'b01; cp_cfg = 4'h1;
    strobe(); check_eq("R1 nonzero cp", int'(seq_busy), 0);
    cp_cfg = 4'h0; sel_cfg = 4'hD;
    strobe(); check_eq("R1 wrong select", int'(seq_busy), 0);
    sel_cfg = 4'hC; tick();

    // R2 R5 R6 basic lengths
    arm_up(12'd5);  measure("R5 length 5", 5);
    check_eq("R6 cp restored", int'(cp_eff), 0);
    arm_up(12'd1);  measure("R5 length 1", 1);
    arm_up(12'd4095); measure("R5 length 4095", 4095);

    // R8 zero count
    arm_up(12'd0); strobe();
    check_eq("R8 zero count", int'(seq_busy), 0);
    tick();

    // R7 restart in the middle
    arm_up(12'd10); strobe();
    repeat (4) tick();
    measure("R7 restart full length", 10);

    // R9 disarm mid interval, then strobe ignored
    arm_up(12'd20); strobe(); tick();
    sel_cfg = 4'h3;
    #1 check_eq("R9 abort same cycle", int'(seq_busy), 0);
    check_eq("R9 cp passthrough", int'(cp_eff), 0);
    strobe(); tick();
    check_eq("R9 strobe ignored", int'(shunt_sw), 0);

    // random mix
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(9) < 7) arm_up(12'($urandom_range(30)));
      else begin
        mode_cfg = 2'($urandom); cp_cfg = 4'($urandom); sel_cfg = 4'($urandom);
        dur_cfg = 12'($urandom_range(30));
      end
      if ($urandom_range(9) < 2) mode_cfg = 2'b01;
      freq_wr = ($urandom_range(9) == 0);
      tick();
    end
    freq_wr = 1'b0;
    tick();
    finish_up();
  end
endmodule